// File: doc/BRIEF.md
# Multiplexed Address Latch Decoder

This block sits beside an 8-bit processor that time-shares its low address pins: early in each memory cycle the pins carry the high address byte, marked by an address strobe, and later they carry the low byte. The block samples the strobe on the system clock. On each rising edge of the strobe it captures the high byte from the shared pins and holds it until the next rising edge. From the held byte it rebuilds the upper address lines A8, A9 and A10. It drives an active-low select for a battery-backed RAM pair and four active-low enables, one for each ROM.

A ROM enable can go low only while the active-low read strobe is low. A mode input sets the ROM bank size. In 1K mode held bits 3:2 choose the ROM. In 2K mode held bits 4:3 choose it. While the active-low reset is low, the RAM select stays inactive so that the battery-backed contents cannot be disturbed.

The control is a three-state machine. ST_EMPTY means nothing has been captured since reset and the last sampled strobe was low. ST_HOLD_LO means a byte is held and the last sampled strobe was low. ST_HOLD_HI means a byte is held and the strobe is still high. The transitions are:
- ST_EMPTY to ST_HOLD_HI when the strobe is high. This captures the byte.
- ST_HOLD_LO to ST_HOLD_HI when the strobe is high. This captures the byte.
- ST_HOLD_HI to ST_HOLD_LO when the strobe falls.
- Every other case keeps the state.
- Reset returns the machine to ST_EMPTY.

Top module: `mal_decoder_top`

## Requirements
- R1: The strobe is sampled on the rising clock edge. The byte on `addr_mux` is captured at the first clock edge that sees the strobe high after seeing it low, or after reset. Holding the strobe high for more cycles does not capture again. The held value persists until the next capture.
- R2: `a_hi[0]` (A8), `a_hi[1]` (A9) and `a_hi[2]` (A10) equal held bits 0, 1 and 2.
- R3: With reset released, `ram_sel_n` is 0 when held bit 5 is 1 and 1 when held bit 5 is 0.
- R4: While `rd_n` is 1, all four bits of `rom_ce_n` are 1.
- R5: With `bank2k` = 0, a held byte present and `rd_n` = 0, only bit k of `rom_ce_n` is 0, where k = 2·(held bit 3) + (held bit 2). Index 0 maps to `rom_ce_n[0]` and index 3 maps to `rom_ce_n[3]`.
- R6: With `bank2k` = 1, a held byte present and `rd_n` = 0, only bit k of `rom_ce_n` is 0, where k = 2·(held bit 4) + (held bit 3).
- R7: While `rst_n` is 0, `ram_sel_n` is 1 and the held byte clears to 0. From reset until the first capture, `rom_ce_n` is 4'b1111.
- R8: A change on `bank2k` or `rd_n` changes `rom_ce_n` in the same cycle, with no new strobe needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_mux | input | 8 | Shared address pins carrying the high byte at strobe time |
| strb | input | 1 | Address strobe, active high |
| rd_n | input | 1 | Active-low memory read strobe |
| bank2k | input | 1 | ROM bank size: 0 selects 1K, 1 selects 2K |
| a_hi | output | 3 | Rebuilt A10:A8 |
| ram_sel_n | output | 1 | Active-low RAM pair select |
| rom_ce_n | output | 4 | Active-low ROM enables, one per ROM |

## Verification
Two functions can act in the same cycle. The first is a capture on the strobe edge. The second is gating by the read strobe or by the mode input, which can change at the edge where a new byte is taken. The bench makes these coincide by raising the strobe and toggling `rd_n` or `bank2k` in the same step. It also asserts reset while the strobe is high. After every clock, a behavioural model of the held byte and the capture history computes the expected outputs, and these are compared with the design's outputs. This shows whether the enables follow the newly captured byte under the new gating and not the old byte or the old gating.

// File: rtl/mal_pkg.sv
package mal_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_HOLD_LO = 2'd1,
        ST_HOLD_HI = 2'd2
    } mal_state_e;

    // Held-byte bit positions; neighbours decode these, so they are fixed.
    localparam int POS_A8   = 0;
    localparam int POS_A10  = 2;
    localparam int POS_BK1K = 2;
    localparam int POS_BK2K = 3;
    localparam int POS_RAM  = 5;

endpackage

// File: rtl/mal_strobe_fsm.sv
module mal_strobe_fsm
    import mal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strb,
    output mal_state_e state,
    output logic       capture,
    output logic       held_valid
);

    mal_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx   = state;
        capture    = 1'b0;
        held_valid = 1'b1;
        unique case (state)
            ST_EMPTY: begin
                held_valid = 1'b0;
                if (strb) begin
                    capture  = 1'b1;
                    state_nx = ST_HOLD_HI;
                end
            end
            ST_HOLD_LO: begin
                if (strb) begin
                    capture  = 1'b1;
                    state_nx = ST_HOLD_HI;
                end
            end
            ST_HOLD_HI: begin
                if (!strb) begin
                    state_nx = ST_HOLD_LO;
                end
            end
            default: begin
                held_valid = 1'b0;
                state_nx   = ST_EMPTY;
            end
        endcase
    end

    // R1: a capture always leaves the machine waiting for the strobe to fall
    assert_capture_to_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (state == ST_HOLD_HI));

    // R1: while the strobe stays high after a capture, no second capture
    assert_no_recapture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD_HI && strb) |-> !capture);

endmodule

// File: rtl/mal_capture.sv
module mal_capture #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] held
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (capture) begin
            held <= addr_in;
        end
    end

    // R1: the held byte changes only at a capture edge
    assert_hold_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(held));

endmodule

// File: rtl/mal_rom_decode.sv
module mal_rom_decode #(
    parameter int NUM_ROM = 4,
    parameter int SEL_W   = $clog2(NUM_ROM)
) (
    input  logic               en,
    input  logic               bank2k,
    input  logic [SEL_W:0]     win,
    output logic [NUM_ROM-1:0] ce_n
);

    logic [SEL_W-1:0] idx;

    // 1K banks use the low window slice, 2K banks the one above it
    assign idx = bank2k ? win[SEL_W:1] : win[SEL_W-1:0];

    for (genvar g = 0; g < NUM_ROM; g++) begin : g_ce
        assign ce_n[g] = !(en && (idx == SEL_W'(g)));
    end

endmodule

// File: rtl/mal_decoder_top.sv
module mal_decoder_top
    import mal_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_ROM = 4,
    parameter int HI_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_mux,
    input  logic               strb,
    input  logic               rd_n,
    input  logic               bank2k,
    output logic [HI_W-1:0]    a_hi,
    output logic               ram_sel_n,
    output logic [NUM_ROM-1:0] rom_ce_n
);

    localparam int SEL_W = $clog2(NUM_ROM);

    mal_state_e        state;
    logic              capture;
    logic              held_valid;
    logic [ADDR_W-1:0] held;
    logic              rom_en;

    mal_strobe_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .strb       (strb),
        .state      (state),
        .capture    (capture),
        .held_valid (held_valid)
    );

    mal_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .addr_in (addr_mux),
        .held    (held)
    );

    assign rom_en = held_valid && !rd_n;

    mal_rom_decode #(.NUM_ROM(NUM_ROM)) u_rom (
        .en     (rom_en),
        .bank2k (bank2k),
        .win    (held[POS_BK1K +: SEL_W+1]),
        .ce_n   (rom_ce_n)
    );

    assign a_hi      = held[POS_A8 +: HI_W];
    assign ram_sel_n = !(rst_n && held[POS_RAM]);

    // R2: the rebuilt lines follow the byte present at the capture edge
    assert_ahi_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (a_hi == $past(addr_mux[HI_W-1:0])));

    // R3: RAM select follows bit 5 of the captured byte
    assert_ram_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (ram_sel_n == !$past(addr_mux[POS_RAM])));

    // R4: read strobe inactive keeps every ROM disabled
    assert_rd_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> (&rom_ce_n));

    // R5/R6: with a byte held and a read, exactly one ROM is enabled
    assert_onehot_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_EMPTY && !rd_n) |-> ($countones(~rom_ce_n) == 1));

    // R7: before the first capture nothing is selected
    assert_empty_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY) |-> (ram_sel_n && (&rom_ce_n)));

endmodule

// File: tb/mal_decoder_top_tb.sv
module mal_decoder_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr_mux = 8'h00;
    logic       strb = 1'b0;
    logic       rd_n = 1'b1;
    logic       bank2k = 1'b0;
    logic [2:0] a_hi;
    logic       ram_sel_n;
    logic [3:0] rom_ce_n;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // Reference model state
    int m_held = 0;
    bit m_prev = 0;
    bit m_cap = 0;

    always #4 clk = ~clk;

    mal_decoder_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_mux  (addr_mux),
        .strb      (strb),
        .rd_n      (rd_n),
        .bank2k    (bank2k),
        .a_hi      (a_hi),
        .ram_sel_n (ram_sel_n),
        .rom_ce_n  (rom_ce_n)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_held = 0;
            m_prev = 0;
            m_cap  = 0;
        end else begin
            if (strb && !m_prev) begin
                m_held = int'(addr_mux);
                m_cap  = 1;
            end
            m_prev = strb;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_rom();
        int k;
        if (!rst_n || !m_cap || rd_n) return 15;
        k = bank2k ? ((m_held >> 3) & 3) : ((m_held >> 2) & 3);
        return 15 & ~(1 << k);
    endfunction

    always @(negedge clk) begin
        cycles++;
        check("R1 R2 a_hi", int'(a_hi), m_held & 7);
        check((rst_n ? "R3 ram_sel_n" : "R7 ram_sel_n"), int'(ram_sel_n),
              (rst_n && ((m_held >> 5) & 1)) ? 0 : 1);
        if (!rst_n || !m_cap)  check("R7 rom_ce_n", int'(rom_ce_n), exp_rom());
        else if (rd_n)         check("R4 rom_ce_n", int'(rom_ce_n), exp_rom());
        else if (bank2k)       check("R6 rom_ce_n", int'(rom_ce_n), exp_rom());
        else                   check("R5 rom_ce_n", int'(rom_ce_n), exp_rom());
        if (cycles > 5000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<5000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input logic s, input logic [7:0] a, input logic r, input logic m);
        @(posedge clk);
        #2;
        strb = s; addr_mux = a; rd_n = r; bank2k = m;
    endtask

    initial begin
        // Reset with strobe high: nothing may be taken (R7)
        step(1'b1, 8'hFF, 1'b0, 1'b0);
        step(1'b1, 8'hFF, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0);
        @(posedge clk); #2; rst_n = 1'b1;
        step(1'b0, 8'h3F, 1'b0, 1'b0);
        step(1'b0, 8'h3F, 1'b0, 1'b0);
        // First capture: 0x25 -> A=5, RAM active, 1K idx 1
        step(1'b1, 8'h25, 1'b0, 1'b0);
        step(1'b0, 8'h1A, 1'b0, 1'b0);
        @(negedge clk);
        check("R5 first capture", int'(rom_ce_n), 4'b1101);
        check("R3 first capture", int'(ram_sel_n), 0);
        // Strobe held high while pins change: no recapture (R1)
        step(1'b1, 8'h12, 1'b0, 1'b0);
        step(1'b1, 8'h2D, 1'b0, 1'b0);
        step(1'b1, 8'h07, 1'b0, 1'b0);
        @(negedge clk);
        check("R1 held while high", int'(a_hi), 2);
        step(1'b0, 8'h07, 1'b0, 1'b0);
        // Mode switch without a strobe: held 0x14 (b2=1,b4=1)
        step(1'b1, 8'h14, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        check("R8 1K view", int'(rom_ce_n), 4'b1101);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        @(negedge clk);
        check("R8 2K view", int'(rom_ce_n), 4'b1011);
        step(1'b0, 8'h00, 1'b1, 1'b1);
        @(negedge clk);
        check("R4 read released", int'(rom_ce_n), 4'b1111);
        // Sweep every 6-bit pattern, both modes, read toggling,
        // with read and mode changing in the capture step itself
        for (int i = 0; i < 128; i++) begin
            step(1'b1, 8'((i * 37) & 8'hFF), logic'(i[2]), logic'(i[0]));
            step(1'b0, 8'hA5, logic'(i[1]), logic'(i[0]));
            step(1'b0, 8'h5A, 1'b0, logic'(~i[0]));
        end
        // Reset arriving with strobe high and RAM selected (R7)
        step(1'b1, 8'h20, 1'b0, 1'b0);
        step(1'b1, 8'h20, 1'b0, 1'b0);
        @(posedge clk); #2; rst_n = 1'b0;
        @(negedge clk);
        check("R7 reset ram", int'(ram_sel_n), 1);
        check("R7 reset rom", int'(rom_ce_n), 4'b1111);
        step(1'b1, 8'h3C, 1'b0, 1'b1);
        @(posedge clk); #2; rst_n = 1'b1;
        step(1'b0, 8'h00, 1'b0, 1'b1);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule